// File: doc/BRIEF.md
# Clock Multiplier Control and Lock Timer

This block is the digital control wrapped around an analog clock multiplier. Software writes three settings: a reference divide ratio, a multiplier setting and a settle count. The block turns the main clock into a divided reference. It decides whether the analog multiplier may run, and it passes the multiplier setting through to it. The nominal multiplier output is the main clock frequency times (MUL + 1), divided by the divide ratio. The analog loop, its filter and its oscillator lie outside the block. Only the control signals that reach them are modelled here.

Any write that alters a setting starts a settle countdown, and so does a write that turns the multiplier back on. The countdown runs on the slow clock. The write crosses into the slow clock domain through a toggle and two-flop handshake. The lock status returns to the main clock domain through two flops. The lock flag falls in the cycle after such a write. It rises again once the countdown has run out. The interrupt output is a level: it is high while the lock flag and the interrupt enable are both set.

The design assumes that rst_n is held low for several slow clock cycles. It also assumes that successive setting-changing writes are spaced far enough apart for each handshake to finish, which is a few slow clock cycles.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, ref_tick_o, mult_en_o, lock_o, irq_o and mul_o are all 0. The stored divide ratio is 0, the stored MUL is 0 and the interrupt enable is off.
- R2: While the stored divide ratio is 0, ref_tick_o stays at 0 and mult_en_o stays at 0.
- R3: While the stored divide ratio D is in the range 1 to 255, ref_tick_o is a one-cycle high pulse. Consecutive pulses start exactly D main clock cycles apart.
- R4: In the cycle after a write, mult_en_o is 1 exactly when the written divide ratio and the written MUL are both nonzero, and mul_o shows the written MUL.
- R5: A write that changes the divide ratio, MUL or the settle count drives lock_o to 0 in the cycle after the write. Turning the multiplier back on is such a change.
- R6: After a setting-changing write with settle count N, with the multiplier enabled, lock_o rises after exactly N+4 slow clock rising edges counted from the write edge. It is high within two main clock cycles of that edge. Two edges synchronise the request, one edge loads the counter, and N+1 edges run it down.
- R7: A write whose divide ratio, MUL and settle count all equal the stored ones does not lower lock_o, even when it changes the interrupt enable.
- R8: irq_o is high exactly when lock_o is high and the stored interrupt enable bit is 1, so it falls whenever lock_o falls.
- R9: While the stored MUL is 0 or the stored divide ratio is 0, lock_o stays at 0 and the settle counter does not run.
- R10: A settle count of 0 raises lock_o after exactly 4 slow clock edges from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Main clock; also the register write clock |
| clk_slow_i | input | 1 | Slow clock that runs the settle counter |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write strobe for the settings |
| wr_div_i | input | 8 | Divide ratio to write (0 stops the reference) |
| wr_mul_i | input | 11 | MUL value to write (0 disables the multiplier) |
| wr_cnt_i | input | 6 | Settle count to write, in slow clock cycles |
| wr_irq_en_i | input | 1 | Interrupt enable to write |
| ref_tick_o | output | 1 | Divided reference pulse |
| mult_en_o | output | 1 | Enable for the analog multiplier |
| mul_o | output | 11 | Stored MUL value driven to the multiplier |
| lock_o | output | 1 | Lock status in the main clock domain |
| irq_o | output | 1 | Lock interrupt level |

## Verification
mult_en_o, mul_o and the fall of lock_o are all due in the first main clock cycle after the write edge. The bench samples them at the falling edge that follows that write. The rise of lock_o is timed in slow clock edges. The bench counts slow rising edges from the write edge up to the first main falling edge at which lock_o is seen high, and expects exactly N+4. The two clocks keep edges at least 2 ns apart, so this count cannot come out one edge early or late. Reference pulse spacing is measured in steady state, from one observed pulse to the next, and must equal the divide ratio.

// File: rtl/pllc_pkg.sv
// Shared widths and the settings record for the clock multiplier control.
package pllc_pkg;
    localparam int unsigned DIV_W = 8;
    localparam int unsigned MUL_W = 11;
    localparam int unsigned CNT_W = 6;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [MUL_W-1:0] mul;
        logic [CNT_W-1:0] cnt;
    } pllc_cfg_t;
endpackage

// File: rtl/pllc_sync2.sv
// Two-flop synchroniser, W bits wide.
// Assumes: each bit is a level or toggle that changes slower than the
// destination clock; bits are not required to arrive together.
module pllc_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pllc_cfg_regs.sv
// Settings registers in the main clock domain.
// Stores the divide ratio, MUL, settle count and interrupt enable.
// Flips a request toggle whenever a write changes any of the three settings.
// Assumes: a new changing write comes only after the previous request has
// been acknowledged by the slow domain.
module pllc_cfg_regs
    import pllc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  pllc_cfg_t wr_cfg,
    input  logic      wr_irq_en,
    output pllc_cfg_t cfg_q,
    output logic      irq_en_q,
    output logic      active,
    output logic      req_tgl,
    output logic      div_restart
);
    logic changed;
    logic div_changed;

    // Detect a change of any setting and of the divide ratio alone.
    always_comb begin
        changed     = (wr_cfg != cfg_q);
        div_changed = (wr_cfg.div != cfg_q.div);
    end

    // Store settings, flip the request toggle on a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            irq_en_q    <= 1'b0;
            req_tgl     <= 1'b0;
            div_restart <= 1'b0;
        end else begin
            div_restart <= 1'b0;
            if (wr_en) begin
                cfg_q    <= wr_cfg;
                irq_en_q <= wr_irq_en;
                if (changed) begin
                    req_tgl <= ~req_tgl;
                end
                div_restart <= div_changed;
            end
        end
    end

    // The multiplier may run only with both a nonzero ratio and a nonzero MUL.
    always_comb begin
        active = (cfg_q.div != '0) && (cfg_q.mul != '0);
    end
endmodule

// File: rtl/pllc_ref_div.sv
// Integer reference divider on the main clock.
// Emits a one-cycle pulse every div cycles; a zero ratio stops it at 0.
// Assumes: restart pulses for one cycle after a change of the ratio.
module pllc_ref_div #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] phase;
    logic [W-1:0] last_phase;

    // Final phase of one period.
    always_comb begin
        last_phase = W'(div - 1'b1);
    end

    // Phase counter and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            tick  <= 1'b0;
        end else if ((div == '0) || restart) begin
            phase <= '0;
            tick  <= 1'b0;
        end else if (phase >= last_phase) begin
            phase <= '0;
            tick  <= 1'b1;
        end else begin
            phase <= phase + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/pllc_lock_timer.sv
// Settle countdown in the slow clock domain.
// Brings in the request toggle and the enable level through two flops.
// A toggle edge loads the count; the lock flag rises one edge after the
// counter reaches zero. The acknowledge toggle returns the last request seen.
// Assumes: the count input is stable for at least three slow edges after
// the request toggle flips.
module pllc_lock_timer #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    input  logic          active,
    input  logic [CW-1:0] cnt_in,
    output logic          ack_tgl,
    output logic          lock_s
);
    logic [1:0]    synced;
    logic          req_s;
    logic          act_s;
    logic          req_prev;
    logic          load;
    logic          busy;
    logic [CW-1:0] ctr;

    pllc_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({req_tgl, active}),
        .q     (synced)
    );

    // Split the synchronised bits and detect a new request.
    always_comb begin
        req_s = synced[1];
        act_s = synced[0];
        load  = req_s ^ req_prev;
    end

    // Count down to lock; stay idle while the multiplier is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
            busy     <= 1'b0;
            lock_s   <= 1'b0;
            ctr      <= '0;
        end else begin
            req_prev <= req_s;
            if (!act_s) begin
                busy   <= 1'b0;
                lock_s <= 1'b0;
                ctr    <= '0;
            end else if (load) begin
                busy   <= 1'b1;
                lock_s <= 1'b0;
                ctr    <= cnt_in;
            end else if (busy) begin
                if (ctr == '0) begin
                    busy   <= 1'b0;
                    lock_s <= 1'b1;
                end else begin
                    ctr <= ctr - 1'b1;
                end
            end
        end
    end

    // Acknowledge the request already acted on.
    always_comb begin
        ack_tgl = req_prev;
    end
endmodule

// File: rtl/pllc_lock_return.sv
// Returns the lock flag to the main clock domain.
// The lock is masked while a request is outstanding or the multiplier is
// off, so it falls in the cycle after a changing write.
// Assumes: the lock flag and the acknowledge toggle change on the same slow edge.
module pllc_lock_return (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic ack_tgl,
    input  logic req_tgl,
    input  logic active,
    input  logic irq_en,
    output logic lock,
    output logic irq
);
    logic [1:0] synced;
    logic       pending;

    pllc_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lock_s, ack_tgl}),
        .q     (synced)
    );

    // Mask the returned lock and derive the interrupt level.
    always_comb begin
        pending = (synced[0] != req_tgl);
        lock    = synced[1] && !pending && active;
        irq     = lock && irq_en;
    end
endmodule

// File: rtl/pll_lock_ctrl.sv
// Top level of the clock multiplier control.
// Settings and reference divider sit in the main domain, the settle counter
// in the slow domain.
// Assumes: rst_n is held for several slow cycles; changing writes are spaced
// so that each handshake finishes.
module pll_lock_ctrl
    import pllc_pkg::*;
(
    input  logic             clk_main_i,
    input  logic             clk_slow_i,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_div_i,
    input  logic [MUL_W-1:0] wr_mul_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    input  logic             wr_irq_en_i,
    output logic             ref_tick_o,
    output logic             mult_en_o,
    output logic [MUL_W-1:0] mul_o,
    output logic             lock_o,
    output logic             irq_o
);
    pllc_cfg_t wr_cfg;
    pllc_cfg_t cfg_q;
    logic      irq_en_q;
    logic      active;
    logic      req_tgl;
    logic      div_restart;
    logic      ack_tgl;
    logic      lock_s;

    // Pack the write fields into one record.
    always_comb begin
        wr_cfg.div = wr_div_i;
        wr_cfg.mul = wr_mul_i;
        wr_cfg.cnt = wr_cnt_i;
    end

    pllc_cfg_regs u_cfg (
        .clk         (clk_main_i),
        .rst_n       (rst_n),
        .wr_en       (wr_en_i),
        .wr_cfg      (wr_cfg),
        .wr_irq_en   (wr_irq_en_i),
        .cfg_q       (cfg_q),
        .irq_en_q    (irq_en_q),
        .active      (active),
        .req_tgl     (req_tgl),
        .div_restart (div_restart)
    );

    pllc_ref_div #(.W(DIV_W)) u_div (
        .clk     (clk_main_i),
        .rst_n   (rst_n),
        .div     (cfg_q.div),
        .restart (div_restart),
        .tick    (ref_tick_o)
    );

    pllc_lock_timer #(.CW(CNT_W)) u_timer (
        .clk     (clk_slow_i),
        .rst_n   (rst_n),
        .req_tgl (req_tgl),
        .active  (active),
        .cnt_in  (cfg_q.cnt),
        .ack_tgl (ack_tgl),
        .lock_s  (lock_s)
    );

    pllc_lock_return u_ret (
        .clk     (clk_main_i),
        .rst_n   (rst_n),
        .lock_s  (lock_s),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .active  (active),
        .irq_en  (irq_en_q),
        .lock    (lock_o),
        .irq     (irq_o)
    );

    // Drive the multiplier controls.
    always_comb begin
        mult_en_o = active;
        mul_o     = cfg_q.mul;
    end
endmodule

// File: rtl/pllc_chk.sv
// Property checker for pll_lock_ctrl, attached by bind.
module pllc_chk
    import pllc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [DIV_W-1:0] wr_div,
    input logic [MUL_W-1:0] wr_mul,
    input logic             ref_tick,
    input logic             mult_en,
    input logic             lock,
    input logic             irq
);
    // R4
    enable_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_div != '0) && (wr_mul != '0)) |=> mult_en);

    // R2
    zero_div_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_div == '0)) |=> !mult_en);

    // R2
    zero_div_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_div == '0)) ##1 !wr_en |=> !ref_tick);

    // R5
    reenable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mult_en) |-> !lock);

    // R9
    idle_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mult_en |-> !lock);

    // R8
    irq_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> lock);

    // R8
    irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> !irq);
endmodule

bind pll_lock_ctrl pllc_chk u_chk (
    .clk      (clk_main_i),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_div   (wr_div_i),
    .wr_mul   (wr_mul_i),
    .ref_tick (ref_tick_o),
    .mult_en  (mult_en_o),
    .lock     (lock_o),
    .irq      (irq_o)
);

// File: tb/pll_lock_ctrl_test.sv
module pll_lock_ctrl_test;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_HALF   = 35;
    localparam int WD_CYCLES   = 150000;
    localparam int LOCK_LIMIT  = 4000;

    logic        clk_main;
    logic        clk_slow;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_div;
    logic [10:0] wr_mul;
    logic [5:0]  wr_cnt;
    logic        wr_irq_en;
    logic        ref_tick;
    logic        mult_en;
    logic [10:0] mul_o;
    logic        lock;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int sl_edges = 0;
    int sl_mark = 0;
    bit done = 0;

    logic [7:0]  cur_div = 0;
    logic [10:0] cur_mul = 0;
    logic [5:0]  cur_cnt = 0;
    logic        cur_ie = 0;

    pll_lock_ctrl uut (
        .clk_main_i  (clk_main),
        .clk_slow_i  (clk_slow),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_div_i    (wr_div),
        .wr_mul_i    (wr_mul),
        .wr_cnt_i    (wr_cnt),
        .wr_irq_en_i (wr_irq_en),
        .ref_tick_o  (ref_tick),
        .mult_en_o   (mult_en),
        .mul_o       (mul_o),
        .lock_o      (lock),
        .irq_o       (irq)
    );

    initial begin
        clk_main = 0;
        forever #(CLK_PERIOD/2) clk_main = ~clk_main;
    end

    initial begin
        clk_slow = 0;
        #3;
        forever #(SLOW_HALF) clk_slow = ~clk_slow;
    end

    always @(posedge clk_slow) sl_edges <= sl_edges + 1;

    function automatic logic exp_en(logic [7:0] d, logic [10:0] m);
        return (d != 0) && (m != 0);
    endfunction

    function automatic int exp_lock_edges(logic [5:0] c);
        return int'(c) + 4;
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(logic [7:0] d, logic [10:0] m, logic [5:0] c, logic ie);
        @(negedge clk_main);
        wr_en = 1; wr_div = d; wr_mul = m; wr_cnt = c; wr_irq_en = ie;
        @(posedge clk_main);
        #1;
        sl_mark = sl_edges;
        @(negedge clk_main);
        wr_en = 0;
        cur_div = d; cur_mul = m; cur_cnt = c; cur_ie = ie;
    endtask

    // Returns slow edges since the write when lock is seen, or -1 on timeout.
    task automatic wait_lock(output int edges);
        edges = -1;
        for (int i = 0; i < LOCK_LIMIT; i++) begin
            if (lock) begin
                edges = sl_edges - sl_mark;
                break;
            end
            @(negedge clk_main);
        end
    endtask

    // Interval between two consecutive reference pulses, or -1 on timeout.
    task automatic pulse_gap(output int gap);
        int waited;
        gap = -1;
        waited = 0;
        while (!ref_tick && waited < 600) begin
            @(negedge clk_main);
            waited++;
        end
        if (ref_tick) begin
            for (int c = 1; c < 600; c++) begin
                @(negedge clk_main);
                if (ref_tick) begin
                    gap = c;
                    break;
                end
            end
        end
    endtask

    task automatic full_cycle(string tag, logic [7:0] d, logic [10:0] m, logic [5:0] c, logic ie);
        int edges;
        int gap;
        do_write(d, m, c, ie);
        chk({tag, " R5 lock cleared"}, int'(lock), 0);
        chk({tag, " R4 mult_en"}, int'(mult_en), int'(exp_en(d, m)));
        chk({tag, " R4 mul_o"}, int'(mul_o), int'(m));
        wait_lock(edges);
        chk({tag, " R6 lock edges"}, edges, exp_lock_edges(c));
        chk({tag, " R8 irq level"}, int'(irq), int'(ie));
        pulse_gap(gap);
        chk({tag, " R3 pulse gap"}, gap, int'(d));
    endtask

    initial begin
        #(WD_CYCLES * CLK_PERIOD);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int edges;
        int ticks;
        logic stayed;
        void'($urandom(32'h5EED1234));
        rst_n = 0; wr_en = 0; wr_div = 0; wr_mul = 0; wr_cnt = 0; wr_irq_en = 0;
        repeat (30) @(negedge clk_main);
        rst_n = 1;
        @(negedge clk_main);

        // R1 reset state
        chk("R1 ref_tick", int'(ref_tick), 0);
        chk("R1 mult_en", int'(mult_en), 0);
        chk("R1 lock", int'(lock), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 mul_o", int'(mul_o), 0);

        // R2 and R9: zero ratio with nonzero MUL
        do_write(8'd0, 11'd5, 6'd2, 1'b1);
        chk("R2 mult_en zero ratio", int'(mult_en), 0);
        ticks = 0;
        stayed = 1;
        repeat (300) begin
            @(negedge clk_main);
            if (ref_tick) ticks++;
            if (lock) stayed = 0;
        end
        chk("R2 no pulses", ticks, 0);
        chk("R9 lock idle zero ratio", int'(stayed), 1);

        // R10: count 0 with ratio 3
        full_cycle("R10", 8'd3, 11'd5, 6'd0, 1'b1);

        // R7: identical settings, interrupt enable dropped
        do_write(cur_div, cur_mul, cur_cnt, 1'b0);
        stayed = 1;
        repeat (40) begin
            @(negedge clk_main);
            if (!lock) stayed = 0;
        end
        chk("R7 lock held on same write", int'(stayed), 1);
        chk("R8 irq off with enable 0", int'(irq), 0);
        do_write(cur_div, cur_mul, cur_cnt, 1'b1);
        @(negedge clk_main);
        chk("R8 irq on with enable 1", int'(irq), 1);

        // R9 and R5: MUL to 0
        do_write(cur_div, 11'd0, cur_cnt, 1'b1);
        chk("R5 lock cleared on disable", int'(lock), 0);
        chk("R9 mult_en off", int'(mult_en), 0);
        chk("R8 irq cleared", int'(irq), 0);
        stayed = 1;
        repeat (400) begin
            @(negedge clk_main);
            if (lock) stayed = 0;
        end
        chk("R9 lock idle zero MUL", int'(stayed), 1);

        // R5 and R6: re-enable with nonzero MUL
        full_cycle("reenable", 8'd1, 11'd7, 6'd5, 1'b1);

        // Directed corner: largest ratio and count
        full_cycle("max", 8'd255, 11'd2047, 6'd63, 1'b0);

        // Random settings
        for (int k = 0; k < 10; k++) begin
            logic [7:0]  d;
            logic [10:0] m;
            logic [5:0]  c;
            logic        ie;
            d  = 8'($urandom_range(255, 1));
            m  = 11'($urandom_range(2047, 1));
            c  = 6'($urandom_range(63, 0));
            ie = 1'($urandom_range(1, 0));
            if (d == cur_div && m == cur_mul && c == cur_cnt) c = c + 1'b1;
            full_cycle("rand", d, m, c, ie);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule